// File: doc/BRIEF.md
# Linear Image Sensor Line Sequencer

This block produces the digital drive waveforms for a two-output linear image sensor whose outputs run in lock step, all from one system clock. Every line carries the transfer gate pulse, an antiblooming gate that also serves as an electronic shutter, two complementary readout register phases, and a reset gate. A capture stage downstream receives a per-pixel strobe and a pixel index. All timing is counted in system clock cycles. The exposure window, the gaps around the transfer pulse, the transfer width and the number of postscan pixels are configuration inputs. The block samples them once, at the first cycle of each line.

Each line passes through a shutter interval, a gap before transfer, the transfer pulse, and a gap after transfer. The register readout follows, made of `PRESCAN` dark pixels and then `USEFUL` image pixels, and after it come the optional postscan pixels. The pixel strobe is a stream with a valid signal and no ready signal. The sensor cannot be stalled, so the stream has no back-pressure, and the consumer must take every beat in the cycle it is offered. A configuration check is applied at line start. When a setting breaks a minimum pulse width or gap, the block raises an error flag for that line and runs the line with safe minimum timing.

Top module: `ccd_seq`

## Requirements
- R1: While `rst` is high, and in idle, the outputs sit at safe levels: `o_xfer`=0, `o_ab`=1, `o_phi1`=1, `o_phi2`=0, `o_rgate`=1, `o_line_start`=0, `o_pix_valid`=0.
- R2: A line runs in this order, one output cycle after the internal state: shutter for `cfg_expo` cycles, gap for `cfg_gap` cycles, `o_xfer` high for `cfg_xfer` cycles, gap for `cfg_gap` cycles, readout, postscan. From line start until readout begins, `o_phi1`=1, `o_phi2`=0 and `o_rgate`=1.
- R3: During readout and postscan, `o_phi1` is high for the first `HALF` cycles of each pixel and `o_phi2` is high for the next `HALF` cycles. A pixel therefore lasts 2*`HALF` cycles, and the two phases are complementary at all times.
- R4: During readout and postscan, `o_rgate` goes high in the first cycle of each `o_phi2` high half and stays high for `RST_W` cycles (`RST_W` < `HALF`). It is low for the rest of the pixel.
- R5: `o_pix_valid` is high for exactly one cycle per useful pixel, in the last `o_phi2` high cycle. The first pulse falls on the fifth phase-2 falling edge of the readout, because pixels 0 to `PRESCAN`-1 are prescan. Each line gives `USEFUL` pulses, with `o_pix_idx` running 0 to `USEFUL`-1.
- R6: After the `PRESCAN`+`USEFUL` register pixels, `cfg_post` extra pixel periods follow. The phases toggle as in R3 and `o_pix_valid` stays low.
- R7: When `cfg_shut_en`=1, `o_ab` is low from line start to the end of the transfer pulse and high from the gap after transfer to the end of the line. Exposure is therefore `cfg_expo`+`cfg_gap` cycles. When `cfg_shut_en`=0, `o_ab` is low for the whole line.
- R8: `o_line_start` is high for one cycle, the cycle just before `o_xfer` rises.
- R9: Configuration inputs are sampled only at line start. Changing them in the middle of a line has no effect until the next line.
- R10: The line is flagged and runs with `cfg_xfer`=`MIN_XFER`, `cfg_gap`=`MIN_GAP`, `cfg_expo`=`MIN_EXPO` when any of the following holds: `cfg_xfer` < `MIN_XFER`, `cfg_gap` < `MIN_GAP`, `cfg_expo` = 0, or `cfg_shut_en`=1 with `cfg_expo`+`cfg_gap` < `MIN_EXPO`. The flag shows on `o_cfg_err` from the first shutter cycle and holds until the next line start.
- R11: When `run` goes low, the current line completes. The block then enters idle with the R1 levels and starts the next line on the first cycle `run` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Start lines while high; stop at line end when low |
| cfg_shut_en | input | 1 | Enable electronic shutter on antiblooming gate |
| cfg_expo | input | CFG_W | Shutter interval length in cycles |
| cfg_gap | input | CFG_W | Gap before and after transfer, in cycles |
| cfg_xfer | input | CFG_W | Transfer pulse width in cycles |
| cfg_post | input | CFG_W | Postscan pixel count |
| o_xfer | output | 1 | Transfer gate |
| o_ab | output | 1 | Antiblooming / shutter gate |
| o_phi1 | output | 1 | Readout register phase 1 |
| o_phi2 | output | 1 | Readout register phase 2 |
| o_rgate | output | 1 | Reset gate |
| o_line_start | output | 1 | One-cycle pulse before transfer |
| o_pix_valid | output | 1 | Useful pixel strobe (no ready) |
| o_pix_idx | output | $clog2(USEFUL) | Useful pixel index |
| o_cfg_err | output | 1 | Current line's configuration was out of range |

## Verification
Every drive output is registered once after the state decode, so each waveform shows one cycle after the internal state that selects it. The error flag comes from the configuration latch and is visible in the first shutter cycle itself. The bench's line model follows this. At each rising edge it records the value for the position the line held before that edge, then it advances, and it compares the value away from the edge. The model keeps its flag value on the current position. Configuration changes are applied a thousand cycles into a line, and the model latches them only at its own line boundary, so any early use of new settings shows up as a mismatch.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  parameter int unsigned CFG_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHUTTER, ST_PRE_GAP, ST_XFER, ST_POST_GAP, ST_READOUT, ST_POSTSCAN
  } seq_state_e;

  typedef struct packed {
    logic             shut_en;
    logic [CFG_W-1:0] expo;
    logic [CFG_W-1:0] gap;
    logic [CFG_W-1:0] xfer;
    logic [CFG_W-1:0] post;
  } line_cfg_t;
endpackage

// File: rtl/ccd_cfg_latch.sv
module ccd_cfg_latch
  import ccd_seq_pkg::*;
#(
  parameter int unsigned MIN_XFER = 31,
  parameter int unsigned MIN_GAP  = 1,
  parameter int unsigned MIN_EXPO = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  line_cfg_t raw,
  output line_cfg_t cur,
  output logic      err
);
  localparam logic [CFG_W-1:0] MX = CFG_W'(MIN_XFER);
  localparam logic [CFG_W-1:0] MG = CFG_W'(MIN_GAP);
  localparam logic [CFG_W-1:0] ME = CFG_W'(MIN_EXPO);
  localparam logic [CFG_W:0]   ME_SUM = (CFG_W+1)'(MIN_EXPO);

  logic      bad;
  logic [CFG_W:0] expo_sum;
  line_cfg_t safe_cfg;

  always_comb begin
    expo_sum = {1'b0, raw.expo} + {1'b0, raw.gap};
    bad = (raw.xfer < MX) || (raw.gap < MG) || (raw.expo == '0) ||
          (raw.shut_en && (expo_sum < ME_SUM));
    safe_cfg         = raw;
    safe_cfg.xfer    = MX;
    safe_cfg.gap     = MG;
    safe_cfg.expo    = ME;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '{shut_en: 1'b0, expo: ME, gap: MG, xfer: MX, post: '0};
      err <= 1'b0;
    end else if (load) begin
      cur <= bad ? safe_cfg : raw;
      err <= bad;
    end
  end
endmodule

// File: rtl/ccd_line_fsm.sv
module ccd_line_fsm
  import ccd_seq_pkg::*;
#(
  parameter int unsigned PRESCAN = 4,
  parameter int unsigned USEFUL  = 2048,
  parameter int unsigned HALF    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  line_cfg_t                   cur,
  output seq_state_e                  state,
  output logic [CFG_W-1:0]            cnt,
  output logic [CFG_W-1:0]            pix,
  output logic [$clog2(2*HALF)-1:0]   hc,
  output logic                        load
);
  localparam int unsigned HC_W    = $clog2(2*HALF);
  localparam int unsigned REG_PIX = PRESCAN + USEFUL;
  localparam logic [HC_W-1:0]  HC_LAST  = HC_W'(2*HALF-1);
  localparam logic [CFG_W-1:0] PIX_LAST = CFG_W'(REG_PIX-1);

  seq_state_e nstate;
  logic       pixel_end, line_end, in_pix;

  always_comb begin
    in_pix    = (state == ST_READOUT) || (state == ST_POSTSCAN);
    pixel_end = in_pix && (hc == HC_LAST);
    line_end  = 1'b0;
    nstate    = state;
    unique case (state)
      ST_IDLE:     if (run) nstate = ST_SHUTTER;
      ST_SHUTTER:  if (cnt == cur.expo - 1'b1) nstate = ST_PRE_GAP;
      ST_PRE_GAP:  if (cnt == cur.gap - 1'b1)  nstate = ST_XFER;
      ST_XFER:     if (cnt == cur.xfer - 1'b1) nstate = ST_POST_GAP;
      ST_POST_GAP: if (cnt == cur.gap - 1'b1)  nstate = ST_READOUT;
      ST_READOUT:
        if (pixel_end && pix == PIX_LAST) begin
          if (cur.post == '0) line_end = 1'b1;
          else nstate = ST_POSTSCAN;
        end
      ST_POSTSCAN:
        if (pixel_end && pix == cur.post - 1'b1) line_end = 1'b1;
      default: nstate = ST_IDLE;
    endcase
    if (line_end) nstate = run ? ST_SHUTTER : ST_IDLE;
    load = run && ((state == ST_IDLE) || line_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pix   <= '0;
      hc    <= '0;
    end else begin
      state <= nstate;
      if (nstate != state || line_end) begin
        cnt <= '0;
        pix <= '0;
        hc  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (in_pix) begin
          hc <= pixel_end ? '0 : hc + 1'b1;
          if (pixel_end) pix <= pix + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccd_drive_decode.sv
module ccd_drive_decode
  import ccd_seq_pkg::*;
#(
  parameter int unsigned PRESCAN = 4,
  parameter int unsigned USEFUL  = 2048,
  parameter int unsigned HALF    = 2,
  parameter int unsigned RST_W   = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  seq_state_e                  state,
  input  logic [CFG_W-1:0]            cnt,
  input  logic [CFG_W-1:0]            pix,
  input  logic [$clog2(2*HALF)-1:0]   hc,
  input  line_cfg_t                   cur,
  output logic                        o_xfer,
  output logic                        o_ab,
  output logic                        o_phi1,
  output logic                        o_phi2,
  output logic                        o_rgate,
  output logic                        o_line_start,
  output logic                        o_pix_valid,
  output logic [$clog2(USEFUL)-1:0]   o_pix_idx
);
  localparam int unsigned HC_W  = $clog2(2*HALF);
  localparam int unsigned IDX_W = $clog2(USEFUL);
  localparam logic [HC_W-1:0]  HC_HALF = HC_W'(HALF);
  localparam logic [HC_W-1:0]  HC_RSTE = HC_W'(HALF + RST_W);
  localparam logic [HC_W-1:0]  HC_LAST = HC_W'(2*HALF-1);
  localparam logic [CFG_W-1:0] PX_LO   = CFG_W'(PRESCAN);
  localparam logic [CFG_W-1:0] PX_HI   = CFG_W'(PRESCAN + USEFUL);

  logic xfer_d, ab_d, p1_d, rg_d, ls_d, vld_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    xfer_d = 1'b0; ab_d = 1'b1; p1_d = 1'b1; rg_d = 1'b1;
    ls_d   = 1'b0; vld_d = 1'b0; idx_d = '0;
    unique case (state)
      ST_SHUTTER:  ab_d = 1'b0;
      ST_PRE_GAP:  begin ab_d = 1'b0; ls_d = (cnt == cur.gap - 1'b1); end
      ST_XFER:     begin ab_d = 1'b0; xfer_d = 1'b1; end
      ST_POST_GAP: ab_d = cur.shut_en;
      ST_READOUT, ST_POSTSCAN: begin
        ab_d  = cur.shut_en;
        p1_d  = hc < HC_HALF;
        rg_d  = (hc >= HC_HALF) && (hc < HC_RSTE);
        vld_d = (state == ST_READOUT) && (hc == HC_LAST) &&
                (pix >= PX_LO) && (pix < PX_HI);
        idx_d = IDX_W'(pix - PX_LO);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_xfer <= 1'b0; o_ab <= 1'b1; o_phi1 <= 1'b1; o_phi2 <= 1'b0;
      o_rgate <= 1'b1; o_line_start <= 1'b0; o_pix_valid <= 1'b0; o_pix_idx <= '0;
    end else begin
      o_xfer <= xfer_d; o_ab <= ab_d; o_phi1 <= p1_d; o_phi2 <= ~p1_d;
      o_rgate <= rg_d; o_line_start <= ls_d; o_pix_valid <= vld_d;
      o_pix_idx <= vld_d ? idx_d : '0;
    end
  end
endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
  import ccd_seq_pkg::*;
#(
  parameter int unsigned PRESCAN  = 4,
  parameter int unsigned USEFUL   = 2048,
  parameter int unsigned HALF     = 2,
  parameter int unsigned RST_W    = 1,
  parameter int unsigned MIN_XFER = 31,
  parameter int unsigned MIN_GAP  = 1,
  parameter int unsigned MIN_EXPO = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run,
  input  logic                      cfg_shut_en,
  input  logic [CFG_W-1:0]          cfg_expo,
  input  logic [CFG_W-1:0]          cfg_gap,
  input  logic [CFG_W-1:0]          cfg_xfer,
  input  logic [CFG_W-1:0]          cfg_post,
  output logic                      o_xfer,
  output logic                      o_ab,
  output logic                      o_phi1,
  output logic                      o_phi2,
  output logic                      o_rgate,
  output logic                      o_line_start,
  output logic                      o_pix_valid,
  output logic [$clog2(USEFUL)-1:0] o_pix_idx,
  output logic                      o_cfg_err
);
  line_cfg_t  raw, cur;
  seq_state_e state;
  logic [CFG_W-1:0] cnt, pix;
  logic [$clog2(2*HALF)-1:0] hc;
  logic load;

  assign raw = '{shut_en: cfg_shut_en, expo: cfg_expo, gap: cfg_gap,
                 xfer: cfg_xfer, post: cfg_post};

  ccd_cfg_latch #(.MIN_XFER(MIN_XFER), .MIN_GAP(MIN_GAP), .MIN_EXPO(MIN_EXPO)) u_cfg (
    .clk(clk), .rst(rst), .load(load), .raw(raw), .cur(cur), .err(o_cfg_err));

  ccd_line_fsm #(.PRESCAN(PRESCAN), .USEFUL(USEFUL), .HALF(HALF)) u_fsm (
    .clk(clk), .rst(rst), .run(run), .cur(cur), .state(state),
    .cnt(cnt), .pix(pix), .hc(hc), .load(load));

  ccd_drive_decode #(.PRESCAN(PRESCAN), .USEFUL(USEFUL), .HALF(HALF), .RST_W(RST_W)) u_dec (
    .clk(clk), .rst(rst), .state(state), .cnt(cnt), .pix(pix), .hc(hc), .cur(cur),
    .o_xfer(o_xfer), .o_ab(o_ab), .o_phi1(o_phi1), .o_phi2(o_phi2), .o_rgate(o_rgate),
    .o_line_start(o_line_start), .o_pix_valid(o_pix_valid), .o_pix_idx(o_pix_idx));
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk #(
  parameter int unsigned USEFUL = 2048
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      o_xfer,
  input logic                      o_ab,
  input logic                      o_phi1,
  input logic                      o_phi2,
  input logic                      o_rgate,
  input logic                      o_line_start,
  input logic                      o_pix_valid,
  input logic [$clog2(USEFUL)-1:0] o_pix_idx
);
  logic [$clog2(USEFUL)-1:0] last_idx;

  always_ff @(posedge clk) begin
    if (rst) last_idx <= '0;
    else if (o_pix_valid) last_idx <= o_pix_idx;
  end

  p_phase_compl_r3: assert property (@(posedge clk) disable iff (rst) o_phi1 != o_phi2);
  p_xfer_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    o_xfer |-> (o_phi1 && !o_phi2 && o_rgate));
  p_ls_lead_r8: assert property (@(posedge clk) disable iff (rst)
    o_line_start |=> $rose(o_xfer));
  p_valid_phi2_r5: assert property (@(posedge clk) disable iff (rst)
    o_pix_valid |-> o_phi2 ##1 !o_phi2);
  p_ab_low_xfer_r7: assert property (@(posedge clk) disable iff (rst) o_xfer |-> !o_ab);
  p_idx_step_r5: assert property (@(posedge clk) disable iff (rst)
    (o_pix_valid && o_pix_idx != '0) |-> (o_pix_idx == last_idx + 1'b1));
endmodule

bind ccd_seq ccd_seq_chk #(.USEFUL(USEFUL)) u_chk (
  .clk(clk), .rst(rst), .o_xfer(o_xfer), .o_ab(o_ab), .o_phi1(o_phi1), .o_phi2(o_phi2),
  .o_rgate(o_rgate), .o_line_start(o_line_start), .o_pix_valid(o_pix_valid),
  .o_pix_idx(o_pix_idx));

// File: tb/ccd_seq_tb_top.sv
module ccd_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4, USE = 2048, H = 2, RW = 1;
  localparam int MINX = 31, MING = 1, MINE = 10;
  localparam int LIMIT = 200000;
  localparam int IW = $clog2(USE);

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, shut_en = 1'b1;
  logic [15:0] expo = 16'd100, gap = 16'd2, xfer = 16'd70, post = 16'd0;
  logic o_xfer, o_ab, o_phi1, o_phi2, o_rgate, o_line_start, o_pix_valid, o_cfg_err;
  logic [IW-1:0] o_pix_idx;

  int checks = 0, fails = 0, cyc = 0, vcount = 0, lines = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_seq dut_i (.clk(clk), .rst(rst), .run(run), .cfg_shut_en(shut_en), .cfg_expo(expo),
    .cfg_gap(gap), .cfg_xfer(xfer), .cfg_post(post), .o_xfer(o_xfer), .o_ab(o_ab),
    .o_phi1(o_phi1), .o_phi2(o_phi2), .o_rgate(o_rgate), .o_line_start(o_line_start),
    .o_pix_valid(o_pix_valid), .o_pix_idx(o_pix_idx), .o_cfg_err(o_cfg_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural line model
  bit m_busy = 0, m_en = 0, m_err = 0;
  int m_t = 0, m_s = MINE, m_g = MING, m_x = MINX, m_p = 0;
  bit e_xfer = 0, e_ab = 1, e_p1 = 1, e_rg = 1, e_ls = 0, e_v = 0;
  int e_idx = 0;

  function automatic int line_len(int s, int g, int x, int p);
    return s + 2*g + x + (PRE + USE + p) * 2 * H;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_busy <= 0; m_t <= 0; m_err <= 0;
      e_xfer <= 0; e_ab <= 1; e_p1 <= 1; e_rg <= 1; e_ls <= 0; e_v <= 0; e_idx <= 0;
    end else begin
      if (!m_busy) begin
        e_xfer <= 0; e_ab <= 1; e_p1 <= 1; e_rg <= 1; e_ls <= 0; e_v <= 0; e_idx <= 0;
      end else begin
        int a, b, c, u, px, hh;
        a = m_s + m_g; b = a + m_x; c = b + m_g;
        e_xfer <= (m_t >= a) && (m_t < b);
        e_ls   <= (m_t == a - 1);
        e_ab   <= (m_t >= b) ? m_en : 1'b0;
        if (m_t < c) begin
          e_p1 <= 1; e_rg <= 1; e_v <= 0; e_idx <= 0;
        end else begin
          u = m_t - c; px = u / (2*H); hh = u % (2*H);
          e_p1 <= (hh < H);
          e_rg <= (hh >= H) && (hh < H + RW);
          e_v  <= (hh == 2*H-1) && (px >= PRE) && (px < PRE + USE);
          e_idx <= ((hh == 2*H-1) && (px >= PRE) && (px < PRE + USE)) ? px - PRE : 0;
        end
      end
      if ((!m_busy && run) || (m_busy && m_t == line_len(m_s, m_g, m_x, m_p) - 1 && run)) begin
        bit bad;
        bad = (xfer < MINX) || (gap < MING) || (expo == 0) ||
              (shut_en && (int'(expo) + int'(gap) < MINE));
        m_busy <= 1; m_t <= 0; m_err <= bad; m_en <= shut_en; m_p <= post;
        m_s <= bad ? MINE : expo; m_g <= bad ? MING : gap; m_x <= bad ? MINX : xfer;
      end else if (m_busy && m_t == line_len(m_s, m_g, m_x, m_p) - 1) begin
        m_busy <= 0;
      end else if (m_busy) begin
        m_t <= m_t + 1;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk(o_xfer == e_xfer, "R2 xfer", o_xfer, e_xfer);
      chk(o_ab == e_ab, "R7 ab", o_ab, e_ab);
      chk(o_phi1 == e_p1 && o_phi2 == !e_p1, "R3 phases", {o_phi1, o_phi2}, {e_p1, !e_p1});
      chk(o_rgate == e_rg, "R4 rgate", o_rgate, e_rg);
      chk(o_line_start == e_ls, "R8 line_start", o_line_start, e_ls);
      chk(o_pix_valid == e_v, "R5 valid", o_pix_valid, e_v);
      if (e_v) chk(o_pix_idx == e_idx, "R5 idx", o_pix_idx, e_idx);
      chk(o_cfg_err == m_err, "R10 cfg_err", o_cfg_err, m_err);
      if (!rst) begin
        if (o_pix_valid) vcount++;
        if (o_line_start) begin
          if (lines > 0) chk(vcount == USE, "R5 pulses per line", vcount, USE);
          vcount = 0; lines++;
        end
      end
    end
  end

  task automatic wait_ls();
    do @(negedge clk); while (!o_line_start);
  endtask

  always @(posedge clk) begin
    if (cyc == LIMIT && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(o_xfer == 0 && o_ab == 1 && o_phi1 == 1 && o_phi2 == 0 && o_rgate == 1,
        "R1 reset levels", {o_xfer, o_ab, o_phi1, o_phi2, o_rgate}, 5'b01101);
    rst = 0;
    @(negedge clk); run = 1;
    // line 1: shutter on, no postscan
    wait_ls();
    repeat (1000) @(negedge clk);
    // R9: mid-line change applies from line 2 only; also R6 postscan and shutter off
    shut_en = 0; expo = 16'd40; gap = 16'd3; xfer = 16'd35; post = 16'd5;
    wait_ls();
    chk(o_cfg_err == 0, "R9 line2 accepted", o_cfg_err, 0);
    repeat (1000) @(negedge clk);
    // line 3: transfer too short -> flagged (R10)
    xfer = 16'd5;
    wait_ls();
    chk(o_cfg_err == 1, "R10 short transfer flagged", o_cfg_err, 1);
    repeat (1000) @(negedge clk);
    // line 4: exposure too short with shutter on -> flagged (R10)
    shut_en = 1; xfer = 16'd40; expo = 16'd4; gap = 16'd2;
    wait_ls();
    chk(o_cfg_err == 1, "R10 short exposure flagged", o_cfg_err, 1);
    repeat (1000) @(negedge clk);
    // line 5: valid short exposure, then stop (R11)
    expo = 16'd8; gap = 16'd2; post = 16'd2;
    wait_ls();
    chk(o_cfg_err == 0, "R10 flag clears", o_cfg_err, 0);
    run = 0;
    repeat (9000) @(negedge clk);
    chk(o_ab == 1 && o_phi1 == 1 && o_rgate == 1 && o_xfer == 0, "R11 idle levels",
        {o_ab, o_phi1, o_rgate, o_xfer}, 4'b1110);
    chk(vcount == USE, "R5 last line pulses", vcount, USE);
    chk(lines == 5, "R8 line count", lines, 5);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule